// File: doc/BRIEF.md
# Tri-Level Sync Separator with Visible-Line Gate

This block takes a digitized sync-detect bit from the luma/sync path of a high-definition component video signal. The bit is high while the signal sits below the sync threshold. The block derives three timing signals from it:

- a horizontal-sync output that follows every sync pulse;
- a vertical-sync flag that rises only for the first broad pulse of a frame;
- a line gate that marks the active picture portion of visible lines.

A two-flop synchronizer brings the input into the clock domain, and all timing is measured from its synchronized edges. The block tells broad pulses from line pulses by looking at the input again a fixed number of clocks after each leading edge. If the input is still high at that point, the pulse is broad.

A line counter is cleared on broad pulses and advanced on line pulses. The gate opens only when the count lies inside a visible-line window. The gate timing is set by two timers, both started at the trailing edge of the synchronized sync pulse. A short delay timer opens the gate. A prescaled duration timer closes it.

Top module: `sync_separator`

## Requirements
- R1: `hsync_o` equals `sync_in` delayed by exactly SYNC_STAGES (2) clocks.
- R2: A pulse is classified CLS_DLY clocks after its synchronized rising edge. It is broad if the synchronized input is still high in that cycle; otherwise it is a line sync. Classification results reach the outputs one clock after the classification cycle.
- R3: A broad pulse clears the line counter to zero. It drives `vsync_o` high only if the count before clearing was greater than VS_MIN_LINES, and low otherwise.
- R4: A line sync drives `vsync_o` low and adds one to the line counter. Between classifications, `vsync_o` holds its value.
- R5: The line counter is LINE_W bits wide. At its all-ones value it stays there on further line syncs instead of wrapping.
- R6: The gate enable is recomputed at every classification from the new count. It is true only for counts from VIS_FIRST to VIS_LAST inclusive. While it is false, `line_gate_o` is low.
- R7: `line_gate_o` can first be high GATE_DLY clocks after the cycle in which the synchronized falling edge is seen.
- R8: A tick counter restarts at each synchronized falling edge and advances once every TICK_DIV clocks. The gate closes in the cycle where that counter reaches GATE_TICKS, which is GATE_TICKS*TICK_DIV clocks after the falling edge.
- R9: Synchronous active-high `rst` clears the synchronizer, the counter, both timers and all outputs. After reset the gate stays low until the count re-enters the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Sync-detect bit, high while the signal is below the sync threshold |
| hsync_o | output | 1 | Synchronized copy of the sync-detect bit |
| vsync_o | output | 1 | High after the first broad pulse of a frame, until the next classification |
| line_gate_o | output | 1 | High during the active portion of visible lines |

## Verification
The properties assume the following about the input:
- line-sync pulses end before their classification point;
- consecutive leading edges are spaced farther apart than the classification delay;
- each gate interval ends before the next trailing edge, so that the open-length bound is meaningful.

The stimulus respects these assumptions. It uses fixed 40-clock lines with pulse widths between 2 and 20 clocks. Widths of 12 and 13 straddle the classification point of a reduced configuration. Broad trains, short frames and an over-long frame that drives the counter into saturation are all built from that line shape.

// File: rtl/sync_sep_pkg.sv
package sync_sep_pkg;

    typedef enum logic {
        KIND_LINE  = 1'b0,
        KIND_BROAD = 1'b1
    } sync_kind_e;

    function automatic logic in_window(input int unsigned value,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (value >= lo) && (value <= hi);
    endfunction

endpackage

// File: rtl/sync_sep_front.sv
module sync_sep_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic sync_s,
    output logic sync_rise,
    output logic sync_fall
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], sync_in};
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_s    = chain_q[SYNC_STAGES-1];
    assign sync_rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
    assign sync_fall = ~chain_q[SYNC_STAGES-1] & chain_q[SYNC_STAGES];

endmodule

// File: rtl/sync_sep_classify.sv
module sync_sep_classify
    import sync_sep_pkg::*;
#(
    parameter int LINE_W       = 11,
    parameter int CLS_DLY      = 80,
    parameter int VS_MIN_LINES = 5,
    parameter int VIS_FIRST    = 35,
    parameter int VIS_LAST     = 1115
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_s,
    input  logic              sync_rise,
    output logic              fire_o,
    output logic              broad_o,
    output logic [LINE_W-1:0] line_o,
    output logic              vsync_o,
    output logic              gate_en_o
);
    localparam int CW = $clog2(CLS_DLY + 1);
    localparam logic [CW-1:0]     CLS_AT   = CW'(CLS_DLY);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;
    localparam logic [LINE_W-1:0] VS_MIN_L = LINE_W'(VS_MIN_LINES);

    typedef struct packed {
        logic              armed;
        logic [CW-1:0]     wait_cnt;
        logic [LINE_W-1:0] line;
        logic              vsync;
        logic              gate_en;
    } cls_state_t;

    cls_state_t st_d, st_q;
    sync_kind_e kind;
    logic       fire;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        kind = sync_s ? KIND_BROAD : KIND_LINE;

        if (st_q.armed) begin
            if (st_q.wait_cnt == CLS_AT) begin
                fire       = 1'b1;
                st_d.armed = 1'b0;
            end else begin
                st_d.wait_cnt = st_q.wait_cnt + 1'b1;
            end
        end

        if (fire) begin
            if (kind == KIND_BROAD) begin
                st_d.vsync = (st_q.line > VS_MIN_L);
                st_d.line  = '0;
            end else begin
                st_d.vsync = 1'b0;
                if (st_q.line != LINE_MAX) st_d.line = st_q.line + 1'b1;
            end
            st_d.gate_en = in_window(int'(st_d.line), VIS_FIRST, VIS_LAST);
        end

        if (sync_rise) begin
            st_d.armed    = 1'b1;
            st_d.wait_cnt = CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign fire_o    = fire;
    assign broad_o   = fire && (kind == KIND_BROAD);
    assign line_o    = st_q.line;
    assign vsync_o   = st_q.vsync;
    assign gate_en_o = st_q.gate_en;

endmodule

// File: rtl/sync_sep_gate.sv
module sync_sep_gate #(
    parameter int GATE_DLY   = 7,
    parameter int GATE_TICKS = 57,
    parameter int TICK_DIV   = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_fall,
    output logic open_o
);
    localparam int DW = $clog2(GATE_DLY + 1);
    localparam int PW = $clog2(TICK_DIV);
    localparam int TW = $clog2(GATE_TICKS + 1);
    localparam logic [DW-1:0] DLY_END  = DW'(GATE_DLY);
    localparam logic [DW-1:0] DLY_OPEN = DW'(GATE_DLY - 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
    localparam logic [TW-1:0] TICK_END = TW'(GATE_TICKS);

    typedef struct packed {
        logic          run;
        logic [DW-1:0] dly;
        logic [PW-1:0] pre;
        logic [TW-1:0] tick;
        logic          open;
    } gate_state_t;

    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        if (st_q.run) begin
            if (st_q.dly != DLY_END) st_d.dly = st_q.dly + 1'b1;
            if (st_q.dly == DLY_OPEN) st_d.open = 1'b1;

            if (st_q.pre == PRE_LAST) begin
                st_d.pre  = '0;
                st_d.tick = st_q.tick + 1'b1;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end

            if (st_d.tick == TICK_END) begin
                st_d.open = 1'b0;
                st_d.run  = 1'b0;
            end
        end

        if (sync_fall) begin
            st_d.run  = 1'b1;
            st_d.dly  = DW'(1);
            st_d.pre  = PW'(1);
            st_d.tick = '0;
            st_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign open_o = st_q.open;

endmodule

// File: rtl/sync_separator.sv
module sync_separator #(
    parameter int LINE_W       = 11,
    parameter int SYNC_STAGES  = 2,
    parameter int CLS_DLY      = 80,
    parameter int VS_MIN_LINES = 5,
    parameter int VIS_FIRST    = 35,
    parameter int VIS_LAST     = 1115,
    parameter int GATE_DLY     = 7,
    parameter int GATE_TICKS   = 57,
    parameter int TICK_DIV     = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic hsync_o,
    output logic vsync_o,
    output logic line_gate_o
);
    logic              sync_s, sync_rise, sync_fall;
    logic              cls_fire, cls_broad;
    logic [LINE_W-1:0] line_q;
    logic              gate_en;
    logic              gate_open;

    sync_sep_front #(.SYNC_STAGES(SYNC_STAGES)) i_front (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (sync_in),
        .sync_s    (sync_s),
        .sync_rise (sync_rise),
        .sync_fall (sync_fall)
    );

    sync_sep_classify #(
        .LINE_W       (LINE_W),
        .CLS_DLY      (CLS_DLY),
        .VS_MIN_LINES (VS_MIN_LINES),
        .VIS_FIRST    (VIS_FIRST),
        .VIS_LAST     (VIS_LAST)
    ) i_classify (
        .clk       (clk),
        .rst       (rst),
        .sync_s    (sync_s),
        .sync_rise (sync_rise),
        .fire_o    (cls_fire),
        .broad_o   (cls_broad),
        .line_o    (line_q),
        .vsync_o   (vsync_o),
        .gate_en_o (gate_en)
    );

    sync_sep_gate #(
        .GATE_DLY   (GATE_DLY),
        .GATE_TICKS (GATE_TICKS),
        .TICK_DIV   (TICK_DIV)
    ) i_gate (
        .clk       (clk),
        .rst       (rst),
        .sync_fall (sync_fall),
        .open_o    (gate_open)
    );

    assign hsync_o     = sync_s;
    assign line_gate_o = gate_open & gate_en;

endmodule

// File: rtl/sync_sep_checker.sv
module sync_sep_checker #(
    parameter int LINE_W      = 11,
    parameter int SYNC_STAGES = 2,
    parameter int VIS_FIRST   = 35,
    parameter int VIS_LAST    = 1115,
    parameter int GATE_DLY    = 7,
    parameter int GATE_TICKS  = 57,
    parameter int TICK_DIV    = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              sync_in,
    input logic              hsync_o,
    input logic              vsync_o,
    input logic              cls_fire,
    input logic              cls_broad,
    input logic [LINE_W-1:0] line_q,
    input logic              gate_en,
    input logic              gate_open
);
    localparam int OPEN_LEN = GATE_TICKS * TICK_DIV - GATE_DLY;
    localparam int RW       = $clog2(OPEN_LEN + 2);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;
    localparam logic [LINE_W-1:0] WIN_LO   = LINE_W'(VIS_FIRST);
    localparam logic [LINE_W-1:0] WIN_HI   = LINE_W'(VIS_LAST);
    localparam logic [RW-1:0]     RUN_LIM  = RW'(OPEN_LEN);

    logic [SYNC_STAGES-1:0] shadow_q;
    logic [RW-1:0]          open_run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q   <= '0;
            open_run_q <= '0;
        end else begin
            shadow_q <= {shadow_q[SYNC_STAGES-2:0], sync_in};
            if (!gate_open)              open_run_q <= '0;
            else if (open_run_q != '1)   open_run_q <= open_run_q + 1'b1;
        end
    end

    AST_HSYNC_DELAY: assert property (@(posedge clk) disable iff (rst)
        hsync_o == shadow_q[SYNC_STAGES-1]); // R1

    AST_BROAD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (cls_fire && cls_broad) |=> (line_q == '0)); // R3

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (rst)
        (cls_fire && !cls_broad && line_q != LINE_MAX) |=> (line_q == $past(line_q) + 1'b1)); // R4

    AST_VSYNC_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !cls_fire |=> $stable(vsync_o)); // R4

    AST_COUNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (line_q == LINE_MAX) |=> (line_q == LINE_MAX || line_q == '0)); // R5

    AST_GATE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        gate_en |-> (line_q >= WIN_LO && line_q <= WIN_HI)); // R6

    AST_GATE_MAX_LEN: assert property (@(posedge clk) disable iff (rst)
        gate_open |-> (open_run_q < RUN_LIM)); // R8

endmodule

bind sync_separator sync_sep_checker #(
    .LINE_W      (LINE_W),
    .SYNC_STAGES (SYNC_STAGES),
    .VIS_FIRST   (VIS_FIRST),
    .VIS_LAST    (VIS_LAST),
    .GATE_DLY    (GATE_DLY),
    .GATE_TICKS  (GATE_TICKS),
    .TICK_DIV    (TICK_DIV)
) i_sync_sep_checker (
    .clk       (clk),
    .rst       (rst),
    .sync_in   (sync_in),
    .hsync_o   (hsync_o),
    .vsync_o   (vsync_o),
    .cls_fire  (cls_fire),
    .cls_broad (cls_broad),
    .line_q    (line_q),
    .gate_en   (gate_en),
    .gate_open (gate_open)
);

// File: tb/test_sync_separator.sv
`timescale 1ns/1ps
module test_sync_separator;
    localparam int LW     = 4;
    localparam int CLS    = 12;
    localparam int VSMIN  = 2;
    localparam int VFIRST = 4;
    localparam int VLAST  = 9;
    localparam int GDLY   = 3;
    localparam int GTICKS = 8;
    localparam int GDIV   = 2;
    localparam int PER    = 40;
    localparam int CNT_MAX = (1 << LW) - 1;
    localparam int K_CLS   = CLS + 3;
    localparam int K_OPEN  = GDLY + 2;
    localparam int K_LAST  = GTICKS * GDIV + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_in = 1'b0;
    logic hsync, vsync, gate;

    int  tests = 0;
    int  fails = 0;
    int  cnt_m = 0;
    bit  vs_m  = 1'b0;
    bit  en_m  = 1'b0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    sync_separator #(
        .LINE_W       (LW),
        .SYNC_STAGES  (2),
        .CLS_DLY      (CLS),
        .VS_MIN_LINES (VSMIN),
        .VIS_FIRST    (VFIRST),
        .VIS_LAST     (VLAST),
        .GATE_DLY     (GDLY),
        .GATE_TICKS   (GTICKS),
        .TICK_DIV     (GDIV)
    ) i_sync_separator (
        .clk         (clk),
        .rst         (rst),
        .sync_in     (sync_in),
        .hsync_o     (hsync),
        .vsync_o     (vsync),
        .line_gate_o (gate)
    );

    task automatic check(input bit act, input bit exp, input string tag, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual %0b expected %0b", tag, what, $time, act, exp);
        end
    endtask

    // One 40-clock line; pulse width h selects line sync (h <= CLS) or broad.
    task automatic run_line(input int h, input string vs_tag);
        bit    broad;
        int    cnt_new;
        bit    vs_new, en_new, open, en_use;
        string gtag;
        broad = (h > CLS);
        if (broad) begin
            vs_new  = (cnt_m > VSMIN);
            cnt_new = 0;
        end else begin
            vs_new  = 1'b0;
            cnt_new = (cnt_m == CNT_MAX) ? CNT_MAX : cnt_m + 1;
        end
        en_new = (cnt_new >= VFIRST) && (cnt_new <= VLAST);
        sync_in = 1'b1;
        for (int k = 1; k <= PER; k++) begin
            @(negedge clk);
            if (k == h) sync_in = 1'b0;
            check(hsync, (k >= 2) && (k <= h + 1), "R1", "hsync");
            check(vsync, (k >= K_CLS) ? vs_new : vs_m, vs_tag, "vsync");
            open   = (k >= h + K_OPEN) && (k <= h + K_LAST);
            en_use = (k >= K_CLS) ? en_new : en_m;
            if (k == h + K_OPEN - 1 || k == h + K_OPEN)      gtag = "R7";
            else if (k == h + K_LAST || k == h + K_LAST + 1) gtag = "R8";
            else if (cnt_new == CNT_MAX)                     gtag = "R5";
            else                                             gtag = "R6";
            check(gate, open && en_use, gtag, "line_gate");
        end
        cnt_m = cnt_new;
        vs_m  = vs_new;
        en_m  = en_new;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sync_in = 1'b0;
        repeat (3) @(negedge clk);
        check(hsync, 1'b0, "R9", "hsync after reset");
        check(vsync, 1'b0, "R9", "vsync after reset");
        check(gate,  1'b0, "R9", "line_gate after reset");
        rst = 1'b0;
        cnt_m = 0;
        vs_m  = 1'b0;
        en_m  = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        do_reset();
        // Short frame start, then a broad train: only the first broad flags.
        for (int i = 0; i < 3; i++) run_line(4, "R4");
        run_line(20, "R3");
        for (int i = 0; i < 4; i++) run_line(20, "R3");
        // Count exactly at the threshold: broad must not flag.
        run_line(2, "R4");
        run_line(6, "R4");
        run_line(13, "R3");
        // Sweep pulse widths through the window, including the width at the classification point.
        for (int i = 0; i < 12; i++) begin
            int h = 2 + (i % 6) * 2;
            run_line(h, (h == CLS) ? "R2" : "R4");
        end
        run_line(13, "R2");
        for (int i = 0; i < 4; i++) run_line(20, "R3");
        // Over-long frame: the counter must hold at its maximum and keep the gate closed.
        for (int i = 0; i < 26; i++) run_line(4, "R5");
        run_line(20, "R3");
        // Reset with the vertical flag high, then re-enter the window from zero.
        do_reset();
        for (int i = 0; i < 6; i++) run_line(4, "R9");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule